// File: doc/BRIEF.md
# Three-Voice Square-Wave Sound Generator

This block produces three 4-bit amplitude codes, one for each of three voices, from a set of sixteen 8-bit control registers that a host writes over a simple address/data bus. Each voice has its own 12-bit square-wave tone divider. All three voices share one pseudo-random noise source and one envelope generator. A mixer register gates tone and noise into each voice. Each voice then emits either a fixed level from its amplitude register or the current envelope level. Two further registers drive general-purpose 8-bit output ports, one of which is meant for parallel printer data.

All timing derives from a prescaled tick: one clock in every `PRESCALE` clocks. The tone, noise and envelope dividers advance only on that tick. The write bus has no back-pressure. A write with `wr_en` high is always accepted at that clock edge and takes effect on the following cycle. The level outputs are plain status-like codes with no handshake. A downstream converter samples them whenever it likes.

Top module: `tri_voice_synth`

## Requirements
- R1: While reset is asserted and on the first cycle after it, all three level outputs and both port outputs are 0.
- R2: A write with `wr_en` high stores `wr_data` into register `wr_addr` at that clock edge. Register 14 appears on `port_a` and register 15 appears on `port_b` on the next cycle. With `wr_en` low, no register changes.
- R3: The tone period of voice v (0=A, 1=B, 2=C) is {register 2v+1 bits 3:0, register 2v}. The voice's square wave toggles once every N prescaled ticks, where N is that period. A period of 0 behaves as 1.
- R4: Register 6 bits 4:0 give the noise period P. Every P ticks, a 17-bit LFSR (seeded with 1) shifts right, and its feedback bit bit0 XOR bit3 enters at bit 16. The noise value is bit 0, so it changes only on period boundaries.
- R5: Mixer register 7 bits 0..2 disable the tone of voices A..C, and bits 3..5 disable their noise, where a bit value of 1 disables the source. A disabled source counts as 1. The voice gate is the AND of both sources, and a closed gate forces the level to 0.
- R6: Amplitude registers 8, 9 and 10 serve voices A, B and C. Bits 3:0 hold the fixed level and bit 4 selects the envelope level instead. Bits 7:5 are ignored.
- R7: The envelope period is {register 12, register 11} ticks per envelope step.
- R8: Register 13 bits are [3] continue, [2] attack, [1] alternate, [0] hold. Writing it restarts the envelope at level 0 when attack is set and at level 15 otherwise, and each step then moves the level one count towards the other end.
- R9: With continue clear, the envelope runs one 16-step ramp and then stays at 0.
- R10: With continue and hold both set, the envelope runs one ramp and then stays at 15 if attack XOR alternate is 1, and at 0 otherwise.
- R11: With continue set and hold clear, the ramp repeats without end. When alternate is set, the direction reverses at each ramp end.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register index 0..15 |
| wr_data | input | 8 | Write data |
| lvl_a | output | 4 | Voice A amplitude code |
| lvl_b | output | 4 | Voice B amplitude code |
| lvl_c | output | 4 | Voice C amplitude code |
| port_a | output | 8 | General-purpose output port A (register 14) |
| port_b | output | 8 | General-purpose output port B (register 15) |

## Verification
The hardest part to reach from the ports is the envelope shape sequence. The prescaler phase is free-running and is not reset by a shape write, so the exact step edges drift by up to one prescale period. To handle this, the stimulus fixes the envelope period at four ticks, opens every voice gate, and writes each of the sixteen shapes in turn. It then samples the level at the middle of each step window, across more than two full ramps, so that the result never depends on the prescaler phase. The tone and noise checks measure the spacing between output changes instead of absolute edge times, for the same reason.

// File: rtl/psg_pkg.sv
package psg_pkg;
  localparam int NCH = 3;

  localparam logic [3:0] A_NOISE = 4'd6;
  localparam logic [3:0] A_MIX   = 4'd7;
  localparam logic [3:0] A_AMP0  = 4'd8;
  localparam logic [3:0] A_EPF   = 4'd11;
  localparam logic [3:0] A_EPC   = 4'd12;
  localparam logic [3:0] A_SHAPE = 4'd13;
  localparam logic [3:0] A_PORTA = 4'd14;
  localparam logic [3:0] A_PORTB = 4'd15;

  typedef struct packed {
    logic cont;
    logic attack;
    logic alt;
    logic hold;
  } shape_t;

  typedef struct packed {
    logic       use_env;
    logic [3:0] lvl;
  } amp_t;
endpackage

// File: rtl/psg_prescaler.sv
module psg_prescaler #(
  parameter int PRESCALE = 8
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);

  logic [PW-1:0] cnt;

  assign tick = (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/psg_divider.sv
module psg_divider #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         restart,
  input  logic [W-1:0] period,
  output logic         expire
);
  logic [W-1:0] cnt;
  logic [W:0]   nxt;
  logic [W:0]   eff;
  logic         last;

  always_comb begin
    eff  = (period == '0) ? {{W{1'b0}}, 1'b1} : {1'b0, period};
    nxt  = {1'b0, cnt} + 1'b1;
    last = (nxt >= eff);
  end

  assign expire = tick & last & ~restart;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (restart) cnt <= '0;
    else if (tick)    cnt <= last ? '0 : nxt[W-1:0];
  end
endmodule

// File: rtl/psg_tone.sv
module psg_tone #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic [W-1:0] period,
  output logic         square
);
  logic expire;

  psg_divider #(.W(W)) u_div (
    .clk(clk), .rst_n(rst_n), .tick(tick), .restart(1'b0),
    .period(period), .expire(expire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      square <= 1'b0;
    else if (expire) square <= ~square;
  end
endmodule

// File: rtl/psg_noise.sv
module psg_noise #(
  parameter int PW  = 5,
  parameter int LW  = 17,
  parameter int TAP = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic [PW-1:0] period,
  output logic          noise
);
  logic          expire;
  logic [LW-1:0] lfsr;
  logic          fb;

  psg_divider #(.W(PW)) u_div (
    .clk(clk), .rst_n(rst_n), .tick(tick), .restart(1'b0),
    .period(period), .expire(expire)
  );

  assign fb    = lfsr[0] ^ lfsr[TAP];
  assign noise = lfsr[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lfsr <= {{(LW-1){1'b0}}, 1'b1};
    else if (expire) lfsr <= {fb, lfsr[LW-1:1]};
  end
endmodule

// File: rtl/psg_envelope.sv
module psg_envelope
  import psg_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         restart,
  input  shape_t       new_shape,
  input  shape_t       shape,
  input  logic [W-1:0] period,
  output logic [3:0]   level
);
  logic       expire;
  logic [3:0] step;
  logic       rising;
  logic       frozen;
  logic [3:0] frozen_lvl;
  logic       ramp_end;

  psg_divider #(.W(W)) u_div (
    .clk(clk), .rst_n(rst_n), .tick(tick), .restart(restart),
    .period(period), .expire(expire)
  );

  assign ramp_end = (step == 4'd15);
  assign level    = frozen ? frozen_lvl : (rising ? step : ~step);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step       <= '0;
      rising     <= 1'b0;
      frozen     <= 1'b1;
      frozen_lvl <= '0;
    end else if (restart) begin
      step       <= '0;
      rising     <= new_shape.attack;
      frozen     <= 1'b0;
      frozen_lvl <= '0;
    end else if (expire && !frozen) begin
      if (!ramp_end) begin
        step <= step + 1'b1;
      end else if (!shape.cont) begin
        frozen     <= 1'b1;
        frozen_lvl <= 4'd0;
      end else if (shape.hold) begin
        frozen     <= 1'b1;
        frozen_lvl <= (shape.attack ^ shape.alt) ? 4'd15 : 4'd0;
      end else begin
        step <= '0;
        if (shape.alt) rising <= ~rising;
      end
    end
  end
endmodule

// File: rtl/tri_voice_synth.sv
module tri_voice_synth
  import psg_pkg::*;
#(
  parameter int PRESCALE = 8,
  parameter int TONE_W   = 12,
  parameter int NOISE_W  = 5,
  parameter int ENV_W    = 16,
  parameter int LFSR_W   = 17
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [3:0] wr_addr,
  input  logic [7:0] wr_data,
  output logic [3:0] lvl_a,
  output logic [3:0] lvl_b,
  output logic [3:0] lvl_c,
  output logic [7:0] port_a,
  output logic [7:0] port_b
);
  localparam int COARSE_W = TONE_W - 8;

  logic [7:0]          tone_fine   [NCH];
  logic [COARSE_W-1:0] tone_coarse [NCH];
  amp_t                amp         [NCH];
  logic [NOISE_W-1:0]  noise_per;
  logic [5:0]          mix;
  logic [7:0]          env_fine, env_coarse;
  shape_t              shape;
  logic                tick;
  logic                noise_bit;
  logic [3:0]          env_lvl;
  logic                env_restart;
  logic [3:0]          lvl [NCH];

  assign env_restart = wr_en && (wr_addr == A_SHAPE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) begin
        tone_fine[i]   <= '0;
        tone_coarse[i] <= '0;
        amp[i]         <= '0;
      end
      noise_per  <= '0;
      mix        <= '0;
      env_fine   <= '0;
      env_coarse <= '0;
      shape      <= '0;
      port_a     <= '0;
      port_b     <= '0;
    end else if (wr_en) begin
      for (int i = 0; i < NCH; i++) begin
        if (wr_addr == 4'(2 * i))     tone_fine[i]   <= wr_data;
        if (wr_addr == 4'(2 * i + 1)) tone_coarse[i] <= wr_data[COARSE_W-1:0];
        if (wr_addr == A_AMP0 + 4'(i)) amp[i]        <= wr_data[4:0];
      end
      case (wr_addr)
        A_NOISE: noise_per  <= wr_data[NOISE_W-1:0];
        A_MIX:   mix        <= wr_data[5:0];
        A_EPF:   env_fine   <= wr_data;
        A_EPC:   env_coarse <= wr_data;
        A_SHAPE: shape      <= wr_data[3:0];
        A_PORTA: port_a     <= wr_data;
        A_PORTB: port_b     <= wr_data;
        default: ;
      endcase
    end
  end

  psg_prescaler #(.PRESCALE(PRESCALE)) u_pre (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  psg_noise #(.PW(NOISE_W), .LW(LFSR_W), .TAP(3)) u_noise (
    .clk(clk), .rst_n(rst_n), .tick(tick), .period(noise_per), .noise(noise_bit)
  );

  psg_envelope #(.W(ENV_W)) u_env (
    .clk(clk), .rst_n(rst_n), .tick(tick), .restart(env_restart),
    .new_shape(shape_t'(wr_data[3:0])), .shape(shape),
    .period(ENV_W'({env_coarse, env_fine})), .level(env_lvl)
  );

  for (genvar v = 0; v < NCH; v++) begin : g_voice
    logic sq;
    logic gate;

    psg_tone #(.W(TONE_W)) u_tone (
      .clk(clk), .rst_n(rst_n), .tick(tick),
      .period({tone_coarse[v], tone_fine[v]}), .square(sq)
    );

    assign gate   = (mix[v] | sq) & (mix[v+3] | noise_bit);
    assign lvl[v] = gate ? (amp[v].use_env ? env_lvl : amp[v].lvl) : 4'd0;
  end

  assign lvl_a = lvl[0];
  assign lvl_b = lvl[1];
  assign lvl_c = lvl[2];
endmodule

// File: rtl/psg_checker.sv
module psg_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [3:0] wr_addr,
  input logic [7:0] wr_data,
  input logic [3:0] lvl_a,
  input logic [3:0] lvl_b,
  input logic [3:0] lvl_c,
  input logic [7:0] port_a,
  input logic [7:0] port_b,
  input logic       tick,
  input logic       noise_bit
);
  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (lvl_a == 4'd0 && lvl_b == 4'd0 && lvl_c == 4'd0 && port_a == 8'd0 && port_b == 8'd0)); // R1

  AST_PORTA_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 4'd14) |=> (port_a == $past(wr_data))); // R2

  AST_PORTB_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 4'd15) |=> (port_b == $past(wr_data))); // R2

  AST_PORTA_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_addr == 4'd14) |=> $stable(port_a)); // R2

  AST_LEVEL_PACED: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({lvl_a, lvl_b, lvl_c}) |-> $past(tick || wr_en)); // R3

  AST_NOISE_PACED: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(noise_bit) |-> $past(tick)); // R4
endmodule

bind tri_voice_synth psg_checker u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .lvl_a(lvl_a), .lvl_b(lvl_b), .lvl_c(lvl_c), .port_a(port_a), .port_b(port_b),
  .tick(tick), .noise_bit(noise_bit)
);

// File: tb/tri_voice_synth_test.sv
module tri_voice_synth_test;
  localparam int PS = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [3:0] lvl_a, lvl_b, lvl_c;
  logic [7:0] port_a, port_b;
  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  tri_voice_synth #(.PRESCALE(PS)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .lvl_a(lvl_a), .lvl_b(lvl_b), .lvl_c(lvl_c), .port_a(port_a), .port_b(port_b)
  );

  function automatic logic [3:0] get_lvl(int ch);
    return (ch == 0) ? lvl_a : (ch == 1) ? lvl_b : lvl_c;
  endfunction

  function automatic int env_model(logic [3:0] shp, int k);
    logic c, at, al, h;
    int r, s;
    logic d;
    {c, at, al, h} = shp;
    if (k < 16) return at ? k : 15 - k;
    if (!c) return 0;
    if (h) return (at ^ al) ? 15 : 0;
    r = k / 16;
    s = k % 16;
    d = at ^ (al & r[0]);
    return d ? s : 15 - s;
  endfunction

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_change(int ch, int limit, output int cyc);
    logic [3:0] v;
    v = get_lvl(ch);
    cyc = 0;
    while (get_lvl(ch) == v && cyc < limit) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  // R3/R5: tone-only gate on one voice, fixed level 15
  task automatic tone_test(int ch, int n);
    int c;
    int eff;
    eff = (n == 0) ? 1 : n;
    wr(4'(2 * ch), 8'(n & 255));
    wr(4'(2 * ch + 1), 8'((n >> 8) & 15));
    wr(4'd7, 8'(8'h3F & ~(8'd1 << ch)));
    wr(4'(8 + ch), 8'h0F);
    wait_change(ch, 4 * eff * PS + 40, c);
    wait_change(ch, 4 * eff * PS + 40, c);
    wait_change(ch, 4 * eff * PS + 40, c);
    check($sformatf("R3 tone half-period ch%0d N=%0d", ch, n), c, eff * PS);
    wait_change(ch, 4 * eff * PS + 40, c);
    check($sformatf("R5 gate low gives level alternation ch%0d", ch), c, eff * PS);
  endtask

  task automatic noise_test(int ch, int p);
    int c, changes;
    int eff;
    eff = (p == 0) ? 1 : p;
    changes = 0;
    wr(4'd6, 8'(p));
    wr(4'd7, 8'(8'h3F & ~(8'd8 << ch)));
    wr(4'(8 + ch), 8'h0F);
    wait_change(ch, 3000, c);
    for (int i = 0; i < 12; i++) begin
      wait_change(ch, 3000, c);
      if (c < 3000) changes++;
      check($sformatf("R4 noise change spacing P=%0d", p), c % (eff * PS), 0);
    end
    check("R4 noise activity", (changes >= 12) ? 1 : 0, 1);
  endtask

  task automatic env_test(logic [3:0] shp);
    int cur;
    int target;
    int exp;
    string tag;
    wr(4'd13, {4'h0, shp});
    cur = 0;
    for (int k = 0; k <= 40; k++) begin
      target = (k * 4 + 2) * PS;
      repeat (target - cur) @(negedge clk);
      cur = target;
      exp = env_model(shp, k);
      if (k == 0) tag = "R8";
      else if (k < 16) tag = "R7";
      else if (!shp[3]) tag = "R9";
      else if (shp[0]) tag = "R10";
      else tag = "R11";
      check($sformatf("%s env shape=%0h step=%0d", tag, shp, k), lvl_a, exp);
    end
  endtask

  initial begin
    logic [7:0] d;
    int n;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    check("R1 reset lvl_a", lvl_a, 0);
    check("R1 reset lvl_b", lvl_b, 0);
    check("R1 reset lvl_c", lvl_c, 0);
    check("R1 reset port_a", port_a, 0);
    check("R1 reset port_b", port_b, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 first cycle lvl_a", lvl_a, 0);

    for (int i = 0; i < 8; i++) begin
      d = 8'($urandom);
      wr(4'd14, d);
      check("R2 port_a write", port_a, d);
      d = 8'($urandom);
      wr(4'd15, d);
      check("R2 port_b write", port_b, d);
    end
    d = port_a;
    @(negedge clk);
    wr_addr = 4'd14; wr_data = ~d; wr_en = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R2 no write when wr_en low", port_a, d);

    wr(4'd7, 8'h3F);
    for (int i = 0; i < 12; i++) begin
      int ch;
      ch = int'($urandom % 3);
      d = 8'($urandom) & 8'hEF;
      wr(4'(8 + ch), d);
      check($sformatf("R6 fixed level ch%0d", ch), get_lvl(ch), int'(d[3:0]));
    end
    wr(4'd8, 8'hEF);
    check("R6 upper amplitude bits ignored", lvl_a, 15);

    tone_test(0, 0);
    tone_test(1, 1);
    tone_test(2, 256);
    for (int i = 0; i < 4; i++) begin
      n = 2 + int'($urandom % 20);
      tone_test(int'($urandom % 3), n);
    end

    noise_test(0, 1);
    noise_test(1, 5);
    noise_test(2, 2 + int'($urandom % 6));

    wr(4'd11, 8'd4);
    wr(4'd12, 8'd0);
    wr(4'd7, 8'h3F);
    wr(4'd8, 8'h10);
    for (int s = 0; s < 16; s++) env_test(4'(s));
    env_test(4'hE);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule